// File: doc/BRIEF.md
# Write-First Bypassing Register File

This block is a general-purpose register file with 32 entries, two independent read ports and one write port. It is meant for a short in-order pipeline. The writeback stage drives the write port while the operand-read stage drives the two read ports in the same cycle. A read whose address matches the register being written in that cycle returns the incoming write data rather than the stored value. This makes the write appear to happen early in the cycle and the reads late. As a result, an instruction that reads a register while its producer is still writing it back gets the correct value. No stall and no forwarding path from writeback to the execute inputs are needed.

Reads are purely combinational: address in, data out, with no clock in between. The write is captured on the rising clock edge. Entry 0 is a constant zero. Writes aimed at it are discarded, and the same-cycle bypass ignores them too. An active-low asynchronous reset clears every entry to zero.

Top module: `rf_wbr_regfile`

## Requirements
- R1: While reset is asserted and after it is released, every register reads as zero on both ports until it is written.
- R2: A write with `wr_en` high stores `wr_data` into entry `wr_addr` on the rising clock edge. From then on, either read port returns that value when addressed.
- R3: When `wr_en` is high and `rd_addr_a` equals a non-zero `wr_addr`, `rd_data_a` shows `wr_data` in the same cycle, before the clock edge.
- R4: When `wr_en` is high and `rd_addr_b` equals a non-zero `wr_addr`, `rd_data_b` shows `wr_data` in the same cycle. Port B does this independently of port A, and both ports may bypass at once.
- R5: Address 0 always reads as zero on both ports. A write to address 0 changes nothing and is not bypassed.
- R6: With `wr_en` low, no register changes and no bypass occurs, whatever `wr_addr` and `wr_data` carry.
- R7: A write changes only the addressed entry. All other entries keep their values.
- R8: Read data follows a change of read address within the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the write is taken on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears all entries |
| rd_addr_a | input | 5 | Register index for read port A |
| rd_data_a | output | 32 | Data for read port A |
| rd_addr_b | input | 5 | Register index for read port B |
| rd_data_b | output | 32 | Data for read port B |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Register index to write |
| wr_data | input | 32 | Value to write |

## Verification
The functions that can meet in one cycle are the write to a register and a read of that same register. The bench provokes this by driving the write strobe, address and data together with a matching read address half a cycle before the edge. It judges the read data at that point, which must already carry the new value, and again after the edge, where the stored value must match. Variants of the same collision cover each port alone, both ports at once, a collision at address 0 (which must stay zero), and a collision with the strobe low (which must show the old value).

// File: rtl/rf_pkg.sv
package rf_pkg;
    localparam int unsigned RF_DEF_NREGS = 32;
    localparam int unsigned RF_DEF_DW    = 32;
    localparam int unsigned RF_NUM_RD    = 2;
endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
    parameter int unsigned NREGS = 32,
    localparam int unsigned AW   = $clog2(NREGS)
) (
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    output logic [NREGS-1:0] wr_sel
);
    always_comb begin
        wr_sel = '0;
        for (int unsigned i = 1; i < NREGS; i++) begin
            wr_sel[i] = wr_en && (wr_addr == AW'(i));
        end
    end
endmodule

// File: rtl/rf_store.sv
module rf_store #(
    parameter int unsigned NREGS = 32,
    parameter int unsigned DW    = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NREGS-1:0]          wr_sel,
    input  logic [DW-1:0]             wr_data,
    output logic [NREGS-1:0][DW-1:0]  regs
);
    typedef struct packed {
        logic [NREGS-1:0][DW-1:0] ent;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int unsigned i = 1; i < NREGS; i++) begin
            if (wr_sel[i]) begin
                st_d.ent[i] = wr_data;
            end
        end
        st_d.ent[0] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign regs = st_q.ent;
endmodule

// File: rtl/rf_rdport.sv
module rf_rdport #(
    parameter int unsigned NREGS = 32,
    parameter int unsigned DW    = 32,
    localparam int unsigned AW   = $clog2(NREGS)
) (
    input  logic [NREGS-1:0][DW-1:0] regs,
    input  logic [AW-1:0]            rd_addr,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [DW-1:0]            wr_data,
    output logic [DW-1:0]            rd_data
);
    logic fwd_hit;

    always_comb begin
        fwd_hit = wr_en && (wr_addr == rd_addr) && (rd_addr != '0);
        if (fwd_hit) begin
            rd_data = wr_data;
        end else begin
            rd_data = regs[rd_addr];
        end
    end
endmodule

// File: rtl/rf_wbr_regfile.sv
module rf_wbr_regfile
    import rf_pkg::*;
#(
    parameter int unsigned NREGS = RF_DEF_NREGS,
    parameter int unsigned DW    = RF_DEF_DW,
    localparam int unsigned AW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr_a,
    output logic [DW-1:0] rd_data_a,
    input  logic [AW-1:0] rd_addr_b,
    output logic [DW-1:0] rd_data_b,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data
);
    logic [NREGS-1:0]          wr_sel;
    logic [NREGS-1:0][DW-1:0]  regs;
    logic [RF_NUM_RD-1:0][AW-1:0] rd_addr_v;
    logic [RF_NUM_RD-1:0][DW-1:0] rd_data_v;

    assign rd_addr_v[0] = rd_addr_a;
    assign rd_addr_v[1] = rd_addr_b;
    assign rd_data_a    = rd_data_v[0];
    assign rd_data_b    = rd_data_v[1];

    rf_wr_decode #(.NREGS(NREGS)) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_sel  (wr_sel)
    );

    rf_store #(.NREGS(NREGS), .DW(DW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .regs    (regs)
    );

    for (genvar p = 0; p < RF_NUM_RD; p++) begin : g_rd
        rf_rdport #(.NREGS(NREGS), .DW(DW)) u_rd (
            .regs    (regs),
            .rd_addr (rd_addr_v[p]),
            .wr_en   (wr_en),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .rd_data (rd_data_v[p])
        );
    end
endmodule

// File: rtl/rf_wbr_chk.sv
module rf_wbr_chk #(
    parameter int unsigned AW = 5,
    parameter int unsigned DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] rd_addr_a,
    input logic [DW-1:0] rd_data_a,
    input logic [AW-1:0] rd_addr_b,
    input logic [DW-1:0] rd_data_b,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data
);
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    a_r3_fwd_a: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != '0 && rd_addr_a == wr_addr) |-> (rd_data_a == wr_data));

    a_r4_fwd_b: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != '0 && rd_addr_b == wr_addr) |-> (rd_data_b == wr_data));

    a_r5_zero_a: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_a == '0) |-> (rd_data_a == '0));

    a_r5_zero_b: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_b == '0) |-> (rd_data_b == '0));

    a_r2_keep_a: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(wr_en) && $past(wr_addr) != '0 && rd_addr_a == $past(wr_addr)
         && !(wr_en && wr_addr == rd_addr_a)) |-> (rd_data_a == $past(wr_data)));

    a_r6_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !$past(wr_en) && !wr_en && $stable(rd_addr_a)) |-> $stable(rd_data_a));

    a_r6_hold_b: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !$past(wr_en) && !wr_en && $stable(rd_addr_b)) |-> $stable(rd_data_b));
endmodule

bind rf_wbr_regfile rf_wbr_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_addr_a (rd_addr_a),
    .rd_data_a (rd_data_a),
    .rd_addr_b (rd_addr_b),
    .rd_data_b (rd_data_b),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
);

// File: tb/tb_rf_wbr_regfile.sv
module tb_rf_wbr_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
    logic [31:0] rd_data_a, rd_data_b;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;

    logic [31:0] model [32];
    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    rf_wbr_regfile dut (
        .clk(clk), .rst_n(rst_n),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Drives a write at the falling edge, lets it be captured, releases it.
    task automatic do_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        if (a != 0) model[a] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset;
        for (int i = 0; i < 32; i++) begin
            rd_addr_a = 5'(i); rd_addr_b = 5'(31 - i);
            #1;
            check("R1 port A", rd_data_a, 32'h0);
            check("R1 port B", rd_data_b, 32'h0);
        end
    endtask

    task automatic t_write_read;
        for (int i = 1; i < 32; i++) do_write(5'(i), 32'hA500_0000 ^ (32'(i) * 32'h0101_0107));
        for (int i = 0; i < 32; i++) begin
            rd_addr_a = 5'(i); rd_addr_b = 5'((i + 7) % 32);
            #1;
            check("R2 port A", rd_data_a, model[i]);
            check("R2 port B", rd_data_b, model[(i + 7) % 32]);
        end
    endtask

    task automatic t_bypass_a;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'd5; wr_data = 32'hDEAD_0005;
        rd_addr_a = 5'd5; rd_addr_b = 5'd6;
        #1;
        check("R3 port A bypass", rd_data_a, 32'hDEAD_0005);
        check("R3 port B untouched", rd_data_b, model[6]);
        @(posedge clk); model[5] = 32'hDEAD_0005;
        @(negedge clk); wr_en = 1'b0; #1;
        check("R3 stored after bypass", rd_data_a, model[5]);
    endtask

    task automatic t_bypass_b;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'd12; wr_data = 32'hBEEF_000C;
        rd_addr_a = 5'd11; rd_addr_b = 5'd12;
        #1;
        check("R4 port B bypass", rd_data_b, 32'hBEEF_000C);
        check("R4 port A untouched", rd_data_a, model[11]);
        rd_addr_a = 5'd12;
        #0.5;
        check("R4 both ports bypass A", rd_data_a, 32'hBEEF_000C);
        check("R4 both ports bypass B", rd_data_b, 32'hBEEF_000C);
        @(posedge clk); model[12] = 32'hBEEF_000C;
        @(negedge clk); wr_en = 1'b0; #1;
        check("R4 stored", rd_data_b, model[12]);
    endtask

    task automatic t_zero;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'd0; wr_data = 32'hFFFF_FFFF;
        rd_addr_a = 5'd0; rd_addr_b = 5'd0;
        #1;
        check("R5 no bypass A", rd_data_a, 32'h0);
        check("R5 no bypass B", rd_data_b, 32'h0);
        @(posedge clk);
        @(negedge clk); wr_en = 1'b0; #1;
        check("R5 reg0 after write A", rd_data_a, 32'h0);
        check("R5 reg0 after write B", rd_data_b, 32'h0);
    endtask

    task automatic t_wen_low;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 5'd7; wr_data = 32'h1234_5678;
        rd_addr_a = 5'd7; rd_addr_b = 5'd7;
        #1;
        check("R6 no bypass when disabled", rd_data_a, model[7]);
        @(posedge clk);
        @(negedge clk); #1;
        check("R6 no store when disabled A", rd_data_a, model[7]);
        check("R6 no store when disabled B", rd_data_b, model[7]);
    endtask

    task automatic t_isolation;
        do_write(5'd9, 32'h0909_0909);
        for (int i = 0; i < 32; i++) begin
            rd_addr_a = 5'(i);
            #0.5;
            check("R7 only addressed entry changes", rd_data_a, model[i]);
        end
    endtask

    task automatic t_comb;
        @(negedge clk);
        rd_addr_a = 5'd3; #0.5;
        check("R8 comb read first", rd_data_a, model[3]);
        rd_addr_a = 5'd30; #0.5;
        check("R8 comb read second", rd_data_a, model[30]);
        rd_addr_b = 5'd9; #0.5;
        check("R8 comb read port B", rd_data_b, model[9]);
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        t_reset;
        @(negedge clk); rst_n = 1'b1;
        t_reset;
        t_write_read;
        t_bypass_a;
        t_bypass_b;
        t_zero;
        t_wen_low;
        t_isolation;
        t_comb;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule